// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block schedules refresh cycles for a DRAM controller that drives up to four banks. It produces one row-strobe (RAS) line per bank, the row address being refreshed, and a busy flag. The access arbiter reads the busy flag and holds off processor cycles while a refresh is running. After a hardware reset the block stays idle and refuses accesses until the first configuration write. That first write opens a warm-up window lasting a parameterised number of clocks. During the window refreshes run back to back and accesses stay blocked. Configuration writes made later update the settings but do not open the window again.

Three sources can request a refresh, and any mix of them may be enabled at once: a free-running interval timer, an external burst request, and a request line that receives an acknowledge. Each refresh uses one of three patterns, chosen at configuration time and latched when the refresh starts. Conventional strobes every enabled bank together. Staggered starts each enabled bank's strobe one clock after the previous bank's. Scrubbing strobes all enabled banks across a read phase followed by a write-back phase at the same row. Every refresh ends with a precharge interval with all strobes low. The row address then advances by one.

Top module: `refresh_sequencer`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `ras`, `busy`, `hs_ack`, `scrub_rd`, `scrub_wr`, `init_active` and `access_ok` are 0 and `ref_row` is 0.
- R2: The clock edge that takes the first `cfg_wr` after reset raises `init_active` for exactly INIT_CYCLES cycles. During that time refreshes start whenever the engine is idle, and `access_ok` is 0. Once the window ends, `access_ok` is 1.
- R3: A `cfg_wr` made while or after the warm-up window runs does not reload or reopen it.
- R4: With only the timer source enabled and the warm-up over, consecutive refreshes start exactly REF_INTERVAL cycles apart.
- R5: While `cfg_burst_en` is set and `burst_req` is high, each refresh completes. The next one starts after exactly one idle cycle. After `burst_req` drops, no further refresh starts from that source.
- R6: When `cfg_hs_en` is set and `hs_req` is high while the engine is idle, a refresh starts and `hs_ack` equals `busy` for that refresh. If `cfg_hs_en` is clear, `hs_req` starts nothing and `hs_ack` stays 0.
- R7: Type code 0 (and the unused code 3) selects conventional refresh: every bank enabled in `cfg_bank_en` is strobed in the same RAS_CYC cycles, and disabled banks are never strobed.
- R8: Type code 1 selects staggered refresh: enabled bank b is strobed in active cycles b through b+RAS_CYC-1, so banks start in order 0, 1, 2, 3, one clock apart.
- R9: Type code 2 selects scrubbing refresh: `scrub_rd` is high for the first RAS_CYC active cycles and `scrub_wr` is high for the next RAS_CYC cycles. The enabled banks stay strobed through both phases, and `busy` covers the whole pair.
- R10: `ref_row` holds the row of the refresh in progress. It increases by one as each refresh finishes and wraps from 2^ROW_W-1 to 0.
- R11: Each refresh keeps `busy` high for its active length (RAS_CYC conventional, RAS_CYC+NUM_BANKS-1 staggered, 2*RAS_CYC scrubbing) plus PRE_CYC precharge cycles with no strobe. Outside a refresh all strobes, scrub flags and `hs_ack` are 0.
- R12: Before the first configuration write no refresh starts, whatever `burst_req` and `hs_req` do, and `access_ok` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_auto_en | input | 1 | Enable the interval-timer refresh source |
| cfg_burst_en | input | 1 | Enable the external burst source |
| cfg_hs_en | input | 1 | Enable the request/acknowledge source |
| cfg_type | input | 2 | Refresh type: 0 conventional, 1 staggered, 2 scrubbing, 3 conventional |
| cfg_bank_en | input | NUM_BANKS | Banks included in a refresh |
| burst_req | input | 1 | External burst refresh request (level) |
| hs_req | input | 1 | Refresh request for the acknowledge handshake (level) |
| ras | output | NUM_BANKS | Per-bank row strobe, active high |
| ref_row | output | ROW_W | Row being refreshed |
| busy | output | 1 | Refresh in progress, including precharge |
| hs_ack | output | 1 | Acknowledge for a refresh started by `hs_req` |
| scrub_rd | output | 1 | Scrub read phase |
| scrub_wr | output | 1 | Scrub write-back phase |
| init_active | output | 1 | Warm-up window running |
| access_ok | output | 1 | Configured and warm-up finished; accesses allowed |

## Verification
The embedded properties assume that `cfg_wr` is a single-cycle pulse. They also assume REF_INTERVAL is larger than one, so two timer ticks never fall on adjacent cycles. Every input changes only between clock edges. The stimulus follows these rules: it drives all inputs one time unit after a rising edge and holds `cfg_wr` for exactly one cycle. It draws random type codes from the full two-bit range, including the unused code, and random bank masks that include the all-off mask. The reference model reads the settings from the cycle before each refresh starts, because a refresh latches its type and mask at its start edge. This holds even when a configuration write lands on that same edge.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [1:0] {
        RT_CONV  = 2'd0,
        RT_STAG  = 2'd1,
        RT_SCRUB = 2'd2
    } ref_type_e;

    typedef enum logic [1:0] {
        ES_IDLE = 2'd0,
        ES_ACT  = 2'd1,
        ES_PRE  = 2'd2
    } eng_state_e;

    function automatic ref_type_e decode_type(input logic [1:0] code);
        case (code)
            2'd1:    return RT_STAG;
            2'd2:    return RT_SCRUB;
            default: return RT_CONV;
        endcase
    endfunction

endpackage

// File: rtl/rfs_cfg_init.sv
module rfs_cfg_init
    import rfs_pkg::*;
#(
    parameter int NB          = 4,
    parameter int INIT_CYCLES = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          auto_en_i,
    input  logic          burst_en_i,
    input  logic          hs_en_i,
    input  logic [1:0]    type_i,
    input  logic [NB-1:0] mask_i,
    output logic          configured,
    output logic          init_active,
    output logic          auto_en,
    output logic          burst_en,
    output logic          hs_en,
    output ref_type_e     typ,
    output logic [NB-1:0] mask
);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        logic              configured;
        logic [INIT_W-1:0] init_cnt;
        logic              auto_en;
        logic              burst_en;
        logic              hs_en;
        ref_type_e         typ;
        logic [NB-1:0]     mask;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_q.init_cnt != '0) begin
            cfg_d.init_cnt = cfg_q.init_cnt - INIT_W'(1);
        end
        if (cfg_wr) begin
            cfg_d.auto_en  = auto_en_i;
            cfg_d.burst_en = burst_en_i;
            cfg_d.hs_en    = hs_en_i;
            cfg_d.typ      = decode_type(type_i);
            cfg_d.mask     = mask_i;
            if (!cfg_q.configured) begin
                cfg_d.configured = 1'b1;
                cfg_d.init_cnt   = INIT_W'(INIT_CYCLES);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign configured  = cfg_q.configured;
    assign init_active = (cfg_q.init_cnt != '0);
    assign auto_en     = cfg_q.auto_en;
    assign burst_en    = cfg_q.burst_en;
    assign hs_en       = cfg_q.hs_en;
    assign typ         = cfg_q.typ;
    assign mask        = cfg_q.mask;

    // R2: the first configuration opens the warm-up window on the next cycle
    p_init_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_q.configured) |=> init_active);

    // R3: once configured and out of the window, the window never returns
    p_init_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.configured && !init_active) |=> !init_active);

endmodule

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int REF_INTERVAL = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_taken,
    output logic pending
);
    localparam int TW = $clog2(REF_INTERVAL);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pend;
    } tmr_state_t;

    tmr_state_t tmr_d, tmr_q;
    logic       tick;

    assign tick = enable && (tmr_q.cnt == TW'(REF_INTERVAL - 1));

    always_comb begin
        tmr_d = tmr_q;
        if (!enable) begin
            tmr_d.cnt  = '0;
            tmr_d.pend = 1'b0;
        end else begin
            tmr_d.cnt  = tick ? '0 : tmr_q.cnt + TW'(1);
            tmr_d.pend = (tmr_q.pend && !start_taken) || tick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign pending = tmr_q.pend;

    // R4: timer ticks are never on adjacent cycles
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R4: a taken request without a new tick clears the pending flag
    p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && start_taken && !tick) |=> !pending);

endmodule

// File: rtl/rfs_engine.sv
module rfs_engine
    import rfs_pkg::*;
#(
    parameter int NB      = 4,
    parameter int ROW_W   = 8,
    parameter int RAS_CYC = 3,
    parameter int PRE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  ref_type_e        cfg_typ,
    input  logic [NB-1:0]    cfg_mask,
    input  logic             hs_req_en,
    output logic [NB-1:0]    ras,
    output logic             busy,
    output logic             scrub_rd,
    output logic             scrub_wr,
    output logic             hs_ack,
    output logic [ROW_W-1:0] row,
    output logic             start
);
    localparam int STAG_LEN  = RAS_CYC + NB - 1;
    localparam int SCRUB_LEN = 2 * RAS_CYC;
    localparam int ACT_MAX   = (STAG_LEN > SCRUB_LEN) ? STAG_LEN : SCRUB_LEN;
    localparam int CNT_MAX   = (ACT_MAX > PRE_CYC) ? ACT_MAX : PRE_CYC;
    localparam int CNT_W     = $clog2(CNT_MAX + NB + RAS_CYC + 1);

    typedef struct packed {
        eng_state_e       state;
        logic [CNT_W-1:0] cnt;
        ref_type_e        typ;
        logic [NB-1:0]    mask;
        logic             ack;
        logic [ROW_W-1:0] row;
    } eng_t;

    eng_t eng_d, eng_q;

    function automatic logic [CNT_W-1:0] act_last(input ref_type_e t);
        case (t)
            RT_STAG:  return CNT_W'(STAG_LEN - 1);
            RT_SCRUB: return CNT_W'(SCRUB_LEN - 1);
            default:  return CNT_W'(RAS_CYC - 1);
        endcase
    endfunction

    always_comb begin
        eng_d = eng_q;
        start = 1'b0;
        case (eng_q.state)
            ES_IDLE: begin
                if (start_req) begin
                    start       = 1'b1;
                    eng_d.state = ES_ACT;
                    eng_d.cnt   = '0;
                    eng_d.typ   = cfg_typ;
                    eng_d.mask  = cfg_mask;
                    eng_d.ack   = hs_req_en;
                end
            end
            ES_ACT: begin
                if (eng_q.cnt == act_last(eng_q.typ)) begin
                    eng_d.state = ES_PRE;
                    eng_d.cnt   = '0;
                end else begin
                    eng_d.cnt = eng_q.cnt + CNT_W'(1);
                end
            end
            ES_PRE: begin
                if (eng_q.cnt == CNT_W'(PRE_CYC - 1)) begin
                    eng_d.state = ES_IDLE;
                    eng_d.cnt   = '0;
                    eng_d.ack   = 1'b0;
                    eng_d.row   = eng_q.row + ROW_W'(1);
                end else begin
                    eng_d.cnt = eng_q.cnt + CNT_W'(1);
                end
            end
            default: eng_d.state = ES_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    logic active;
    assign active = (eng_q.state == ES_ACT);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(b);
        localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(b + RAS_CYC);
        logic win;
        if (b == 0) begin : g_first
            assign win = (eng_q.cnt < WIN_HI);
        end else begin : g_rest
            assign win = (eng_q.cnt >= WIN_LO) && (eng_q.cnt < WIN_HI);
        end
        assign ras[b] = active && eng_q.mask[b] && ((eng_q.typ != RT_STAG) || win);
    end

    assign busy     = (eng_q.state != ES_IDLE);
    assign scrub_rd = active && (eng_q.typ == RT_SCRUB) && (eng_q.cnt <  CNT_W'(RAS_CYC));
    assign scrub_wr = active && (eng_q.typ == RT_SCRUB) && (eng_q.cnt >= CNT_W'(RAS_CYC));
    assign hs_ack   = eng_q.ack;
    assign row      = eng_q.row;

    // R9: read and write-back phases never overlap
    p_scrub_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(scrub_rd && scrub_wr));

    // R9: the end of the read phase is followed directly by the write-back
    p_scrub_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scrub_rd) |-> scrub_wr);

    // R10: the row advances by exactly one when a refresh finishes
    p_row_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (row == $past(row) + ROW_W'(1)));

    // R6: the acknowledge lives only inside a refresh
    p_ack_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack |-> busy);

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
    import rfs_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int ROW_W        = 8,
    parameter int REF_INTERVAL = 40,
    parameter int INIT_CYCLES  = 200,
    parameter int RAS_CYC      = 3,
    parameter int PRE_CYC      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic                 cfg_auto_en,
    input  logic                 cfg_burst_en,
    input  logic                 cfg_hs_en,
    input  logic [1:0]           cfg_type,
    input  logic [NUM_BANKS-1:0] cfg_bank_en,
    input  logic                 burst_req,
    input  logic                 hs_req,
    output logic [NUM_BANKS-1:0] ras,
    output logic [ROW_W-1:0]     ref_row,
    output logic                 busy,
    output logic                 hs_ack,
    output logic                 scrub_rd,
    output logic                 scrub_wr,
    output logic                 init_active,
    output logic                 access_ok
);
    logic                 configured;
    logic                 auto_en, burst_en, hs_en;
    ref_type_e            typ;
    logic [NUM_BANKS-1:0] mask;
    logic                 pending;
    logic                 start;
    logic                 hs_req_en;
    logic                 start_req;

    rfs_cfg_init #(
        .NB          (NUM_BANKS),
        .INIT_CYCLES (INIT_CYCLES)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .auto_en_i   (cfg_auto_en),
        .burst_en_i  (cfg_burst_en),
        .hs_en_i     (cfg_hs_en),
        .type_i      (cfg_type),
        .mask_i      (cfg_bank_en),
        .configured  (configured),
        .init_active (init_active),
        .auto_en     (auto_en),
        .burst_en    (burst_en),
        .hs_en       (hs_en),
        .typ         (typ),
        .mask        (mask)
    );

    rfs_interval_timer #(
        .REF_INTERVAL (REF_INTERVAL)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (configured && auto_en),
        .start_taken (start),
        .pending     (pending)
    );

    assign hs_req_en = hs_en && hs_req;
    assign start_req = configured &&
                       (init_active || pending || (burst_en && burst_req) || hs_req_en);

    rfs_engine #(
        .NB      (NUM_BANKS),
        .ROW_W   (ROW_W),
        .RAS_CYC (RAS_CYC),
        .PRE_CYC (PRE_CYC)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .cfg_typ   (typ),
        .cfg_mask  (mask),
        .hs_req_en (hs_req_en),
        .ras       (ras),
        .busy      (busy),
        .scrub_rd  (scrub_rd),
        .scrub_wr  (scrub_wr),
        .hs_ack    (hs_ack),
        .row       (ref_row),
        .start     (start)
    );

    assign access_ok = configured && !init_active;

    // R12: nothing refreshes before the first configuration write
    p_idle_unconf_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !configured |-> !busy);

    // R11: no strobe outside a refresh
    p_ras_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|ras) |-> busy);

    // R2: accesses are refused throughout the warm-up window
    p_no_access_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_active |-> !access_ok);

endmodule

// File: tb/sim_refresh_sequencer.sv
module sim_refresh_sequencer;
    localparam int NB = 4;
    localparam int RW = 8;
    localparam int RI = 40;
    localparam int IC = 200;
    localparam int RC = 3;
    localparam int PC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0, cfg_auto_en = 1'b0, cfg_burst_en = 1'b0, cfg_hs_en = 1'b0;
    logic [1:0]    cfg_type = 2'd0;
    logic [NB-1:0] cfg_bank_en = '0;
    logic          burst_req = 1'b0, hs_req = 1'b0;
    logic [NB-1:0] ras;
    logic [RW-1:0] ref_row;
    logic          busy, hs_ack, scrub_rd, scrub_wr, init_active, access_ok;

    refresh_sequencer #(
        .NUM_BANKS(NB), .ROW_W(RW), .REF_INTERVAL(RI),
        .INIT_CYCLES(IC), .RAS_CYC(RC), .PRE_CYC(PC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_auto_en(cfg_auto_en),
        .cfg_burst_en(cfg_burst_en), .cfg_hs_en(cfg_hs_en), .cfg_type(cfg_type),
        .cfg_bank_en(cfg_bank_en), .burst_req(burst_req), .hs_req(hs_req),
        .ras(ras), .ref_row(ref_row), .busy(busy), .hs_ack(hs_ack),
        .scrub_rd(scrub_rd), .scrub_wr(scrub_wr), .init_active(init_active),
        .access_ok(access_ok)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // reference model of the requirements
    function automatic int map_t(input int code);
        return (code == 1) ? 1 : (code == 2) ? 2 : 0;
    endfunction

    function automatic int act_len(input int t);
        return (t == 1) ? RC + NB - 1 : (t == 2) ? 2 * RC : RC;
    endfunction

    function automatic logic [NB-1:0] exp_ras(input int t, input logic [NB-1:0] m, input int k);
        logic [NB-1:0] r = '0;
        for (int b = 0; b < NB; b++) begin
            if (t == 1) r[b] = m[b] && (k >= b) && (k < b + RC);
            else        r[b] = m[b] && (k < act_len(t));
        end
        return r;
    endfunction

    // configuration model (mirrors the registered settings)
    int            m_t = 0;
    logic [NB-1:0] m_m = '0;
    bit            m_h = 1'b0;
    int            s_t = 0, c_t = 0;
    logic [NB-1:0] s_m = '0, c_m = '0;
    bit            s_h = 1'b0, c_h = 1'b0;

    task automatic cfg(input int code, input logic [NB-1:0] m, input bit a, input bit b, input bit h);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_type = 2'(code); cfg_bank_en = m;
        cfg_auto_en = a; cfg_burst_en = b; cfg_hs_en = h;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        m_t = map_t(code); m_m = m; m_h = h;
    endtask

    // monitor
    longint        cyc = 0, fall_cyc = 0, last_st = 0;
    int            k = 0, n_start = 0, n_auto = 0, init_seen = 0;
    bit            busy_p = 1'b0, gap_on = 1'b0, fall_ok = 1'b0, auto_on = 1'b0;
    logic [RW-1:0] m_row = '0;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            busy_p = 1'b0; m_row = '0; k = 0;
        end else begin
            if (init_active) init_seen++;
            if (busy && !busy_p) begin
                c_t = s_t; c_m = s_m; c_h = s_h; k = 0; n_start++;
                chk(ref_row == m_row, "R10", ref_row, m_row);
                if (gap_on && fall_ok) chk(cyc - fall_cyc == 1, "R5", cyc - fall_cyc, 1);
                if (auto_on) begin
                    if (n_auto >= 2) chk(cyc - last_st == RI, "R4", cyc - last_st, RI);
                    n_auto++;
                    last_st = cyc;
                end
            end
            if (busy) begin
                chk(ras == exp_ras(c_t, c_m, k), (c_t == 1) ? "R8" : (c_t == 2) ? "R9" : "R7",
                    ras, exp_ras(c_t, c_m, k));
                chk(scrub_rd == (c_t == 2 && k < RC), "R9", scrub_rd, (c_t == 2 && k < RC));
                chk(scrub_wr == (c_t == 2 && k >= RC && k < 2 * RC), "R9", scrub_wr,
                    (c_t == 2 && k >= RC && k < 2 * RC));
                chk(hs_ack == c_h, "R6", hs_ack, c_h);
                if (k >= act_len(c_t) + PC) chk(1'b0, "R11", k + 1, act_len(c_t) + PC);
                k++;
            end else begin
                if (busy_p) begin
                    chk(k == act_len(c_t) + PC, "R11", k, act_len(c_t) + PC);
                    m_row = m_row + 1'b1;
                    if (gap_on) begin fall_cyc = cyc; fall_ok = 1'b1; end
                end
                chk(ras == '0 && !scrub_rd && !scrub_wr && !hs_ack, "R11",
                    {ras, scrub_rd, scrub_wr, hs_ack}, 0);
            end
            s_t = m_t; s_m = m_m; s_h = m_h && hs_req;
            busy_p = busy;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_sim();
    end

    initial begin
        int seed_v;
        int tgt;
        seed_v = $urandom(32'd20240611);

        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(ras == '0 && !busy && !hs_ack && !init_active && !access_ok && ref_row == '0,
            "R1", {ras, busy, hs_ack, init_active, access_ok}, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk(ras == '0 && !busy && !hs_ack && !scrub_rd && !scrub_wr && ref_row == '0,
            "R1", {ras, busy, hs_ack, scrub_rd, scrub_wr}, 0);
        chk(!init_active && !access_ok, "R1", {init_active, access_ok}, 0);

        // R12: requests before configuration are ignored
        @(posedge clk); #1; burst_req = 1'b1; hs_req = 1'b1;
        repeat (20) begin
            @(negedge clk);
            chk(!busy && !access_ok, "R12", {busy, access_ok}, 0);
        end
        @(posedge clk); #1; burst_req = 1'b0; hs_req = 1'b0;

        // R2 / R3: warm-up window, reconfigured half way through
        fall_ok = 1'b0; gap_on = 1'b1;
        cfg(0, 4'b1111, 1'b0, 1'b0, 1'b0);
        repeat (50) begin
            @(negedge clk);
            chk(init_active && !access_ok, "R2", {init_active, access_ok}, 2);
        end
        cfg(1, 4'b1011, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        while (init_active) begin
            chk(!access_ok, "R2", access_ok, 0);
            @(negedge clk);
        end
        chk(init_seen == IC, "R3", init_seen, IC);
        chk(access_ok, "R2", access_ok, 1);
        chk(n_start >= IC / (act_len(1) + PC + 1) - 1, "R2", n_start, IC / (act_len(1) + PC + 1) - 1);
        gap_on = 1'b0;
        while (busy) @(negedge clk);

        // R3: a later write leaves the window closed
        cfg(2, 4'b0001, 1'b0, 1'b0, 1'b0);
        repeat (10) begin
            @(negedge clk);
            chk(!init_active && access_ok && !busy, "R3", {init_active, access_ok, busy}, 2);
        end

        // R4: timer only, staggered
        cfg(1, 4'b1111, 1'b1, 1'b0, 1'b0);
        n_auto = 0; auto_on = 1'b1;
        repeat (8 * RI + 10) @(negedge clk);
        chk(n_auto >= 8, "R4", n_auto, 8);
        auto_on = 1'b0;
        cfg(0, 4'b0000, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        while (busy) @(negedge clk);

        // R5 / R10: long scrubbing burst, row wraps
        cfg(2, 4'b0101, 1'b0, 1'b1, 1'b0);
        fall_ok = 1'b0; gap_on = 1'b1;
        @(posedge clk); #1; burst_req = 1'b1;
        tgt = n_start + 260;
        while (n_start < tgt) @(negedge clk);
        @(posedge clk); #1; burst_req = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
        gap_on = 1'b0;
        repeat (20) begin
            @(negedge clk);
            chk(!busy, "R5", busy, 0);
        end

        // R6: handshake with acknowledge
        cfg(0, 4'b0110, 1'b0, 1'b0, 1'b1);
        @(posedge clk); #1; hs_req = 1'b1;
        @(negedge clk);
        while (!busy) @(negedge clk);
        chk(hs_ack, "R6", hs_ack, 1);
        @(posedge clk); #1; hs_req = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (10) begin
            @(negedge clk);
            chk(!busy && !hs_ack, "R6", {busy, hs_ack}, 0);
        end

        // R6: request ignored when the source is disabled
        cfg(0, 4'b1111, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1; hs_req = 1'b1;
        repeat (15) begin
            @(negedge clk);
            chk(!busy && !hs_ack, "R6", {busy, hs_ack}, 0);
        end
        @(posedge clk); #1; hs_req = 1'b0;

        // random phases mixing sources, types and masks
        for (int ph = 0; ph < 30; ph++) begin
            cfg($urandom_range(0, 3), NB'($urandom_range(0, 15)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            repeat (200) begin
                @(posedge clk); #1;
                if ($urandom_range(0, 9) == 0) burst_req = ~burst_req;
                if ($urandom_range(0, 7) == 0) hs_req = ~hs_req;
            end
        end
        @(posedge clk); #1; burst_req = 1'b0; hs_req = 1'b0;
        repeat (20) @(negedge clk);
        finish_sim();
    end
endmodule